// File: doc/BRIEF.md
# Descriptor Ring Stream DMA

The block moves words between a buffer memory and two word streams by walking a closed ring of buffer descriptors. The descriptors sit in a small internal table, one table per channel. The playback channel reads a buffer and presents its words on an output stream. The capture channel takes words from an input stream and writes them into a buffer. Each descriptor has three words:

- a control word with two size fields, flags and a hardware-ownership bit;
- a buffer base address;
- the index of the next descriptor.

Software starts a channel by giving it a start index and a start pulse. The engine then follows the links on its own. When it finishes a descriptor whose end-of-frame flag is set, it sets a per-channel status bit and latches that descriptor's index. A capture completion also hands the descriptor back to software by clearing its ownership bit. The capture channel therefore stalls on the next lap unless software returns each descriptor. A playback completion leaves ownership alone, so playback keeps cycling the ring.

Software reads and writes the descriptor tables through a single word-wide port. Each channel reaches buffer memory through its own simple port. Reads on that port are combinational and writes complete on the clock edge.

Top module: `ring_dma`

## Requirements
- R1: After reset, every descriptor `i` of each channel holds the following:
  - the control word `{owner=1, eof=1, sub_sof=0, 5'b0, datalen=BUF_BYTES, blocksize=BUF_BYTES}`. `blocksize` is in bits 11:0, `datalen` in bits 23:12, `sub_sof` in bit 29, `eof` in bit 30 and `owner` in bit 31. With the defaults the word is 0xC0100100.
  - buffer address `i*BUF_BYTES/4`;
  - link `(i+1) mod N_DESC`.
- R2: Playback presents the words at buffer addresses base, base+1, ... of each descriptor in link order. It presents `datalen/4` words per descriptor (zero-length descriptors complete at once), and it wraps around the ring.
- R3: Playback honours backpressure: while `pb_valid` is high and `pb_ready` is low, the word and its memory address are held and nothing is skipped.
- R4: Capture raises `cp_ready` only while it can accept data. It writes `blocksize/4` accepted words per descriptor to consecutive buffer addresses, and a word moves only when `cp_valid` and `cp_ready` are both high.
- R5: Completing a descriptor with `eof=1` sets that channel's status bit (bit 0 playback, bit 1 capture) and latches the descriptor's index on `pb_eof_idx`/`cp_eof_idx`. A descriptor with `eof=0` changes neither.
- R6: Capture clears the `owner` bit (bit 31) of each descriptor it completes. Playback leaves `owner` at 1.
- R7: A channel that reaches a descriptor with `owner=0` stops, raises its `stall` bit and ignores its stream. It resumes by itself once software sets that `owner` bit back to 1.
- R8: Writing a 1 to a status bit through `sts_we`/`sts_wdata` clears that bit, so writing all ones clears both. A completion in the same cycle takes priority over the clear. `irq` is high when any status bit is set and enabled in `irq_en`.
- R9: A start pulse makes the channel fetch from its start index, abandoning any transfer in progress.
- R10: Software descriptor accesses use `dsc_sel` 0 for the control word, 1 for the buffer address and 2 for the link, on the table chosen by `dsc_ch` (0 playback, 1 capture). `dsc_rdata` reads back the selected word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 2 | Start pulse per channel (bit 0 playback, bit 1 capture) |
| pb_start_idx | input | IDX_W | Playback start descriptor index |
| cp_start_idx | input | IDX_W | Capture start descriptor index |
| dsc_we | input | 1 | Descriptor write strobe |
| dsc_ch | input | 1 | Descriptor table select |
| dsc_idx | input | IDX_W | Descriptor index |
| dsc_sel | input | 2 | Descriptor word select |
| dsc_wdata | input | 32 | Descriptor write data |
| dsc_rdata | output | 32 | Descriptor read data |
| irq_en | input | 2 | Per-channel interrupt enable |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 2 | Status bits to clear |
| irq_sts | output | 2 | Per-channel completion status |
| irq | output | 1 | Interrupt request |
| pb_eof_idx | output | IDX_W | Last completed end-of-frame playback descriptor |
| cp_eof_idx | output | IDX_W | Last completed end-of-frame capture descriptor |
| stall | output | 2 | Channel halted on a software-owned descriptor |
| pb_mem_addr | output | AW | Playback buffer read address |
| pb_mem_rdata | input | DW | Playback buffer read data |
| pb_valid | output | 1 | Playback word valid |
| pb_ready | input | 1 | Playback sink ready |
| pb_data | output | DW | Playback word |
| cp_mem_addr | output | AW | Capture buffer write address |
| cp_mem_we | output | 1 | Capture buffer write enable |
| cp_mem_wdata | output | DW | Capture buffer write data |
| cp_valid | input | 1 | Capture word valid |
| cp_ready | output | 1 | Capture channel ready |
| cp_data | input | DW | Capture word |

## Verification
Three playback patterns are used:

- a ring with one link rewritten and one descriptor shortened, drained with a sink that is ready only two cycles in three: a lost, repeated or reordered word appears as a scoreboard mismatch;
- a restart at a mid-ring descriptor whose end-of-frame flag is clear: this separates start-index handling and end-of-frame gating from plain ring wrap;
- no further words requested after the first lap, so the engine waits on the next descriptor: this shows that the word and its address are held.

Capture is fed words with gaps on a ring where one descriptor is shorter and has no end-of-frame flag. The bench then drives junk while the channel is stalled, returns a single descriptor and feeds one more block. This checks that ownership is cleared per completion, that a stalled channel ignores its input, and that it resumes only for the descriptor handed back.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    // Control word, LSB upward: blocksize, datalen, reserved, sub_sof, eof, owner.
    typedef struct packed {
        logic        owner;
        logic        eof;
        logic        sub_sof;
        logic [4:0]  rsvd;
        logic [11:0] datalen;
        logic [11:0] blocksize;
    } dsc_ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BUF  = 2'd1,
        SEL_LINK = 2'd2
    } dsc_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_DONE,
        ST_STALL
    } eng_state_t;

    function automatic dsc_ctrl_t init_ctrl(input logic [11:0] nbytes);
        dsc_ctrl_t c;
        c.owner     = 1'b1;
        c.eof       = 1'b1;
        c.sub_sof   = 1'b0;
        c.rsvd      = '0;
        c.datalen   = nbytes;
        c.blocksize = nbytes;
        return c;
    endfunction

    function automatic logic [11:0] bytes_to_words(input logic [11:0] nbytes);
        return {2'b00, nbytes[11:2]};
    endfunction

endpackage

// File: rtl/ring_dma_table.sv
module ring_dma_table
    import ring_dma_pkg::*;
#(
    parameter int N_DESC         = 8,
    parameter int BUF_WORDS      = 64,
    parameter int AW             = 12,
    parameter bit LEN_FROM_BLOCK = 1'b0,
    localparam int IDX_W         = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we_i,
    input  logic [IDX_W-1:0] sw_idx_i,
    input  logic [1:0]       sw_sel_i,
    input  logic [31:0]      sw_wdata_i,
    output logic [31:0]      sw_rdata_o,
    input  logic [IDX_W-1:0] hw_idx_i,
    input  logic             hw_clr_i,
    output logic             hw_owner_o,
    output logic             hw_eof_o,
    output logic [11:0]      hw_len_o,
    output logic [AW-1:0]    hw_buf_o,
    output logic [IDX_W-1:0] hw_link_o
);

    dsc_ctrl_t        ctrl_q [N_DESC];
    logic [AW-1:0]    buf_q  [N_DESC];
    logic [IDX_W-1:0] link_q [N_DESC];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_DESC; i++) begin
            if (rst) begin
                ctrl_q[i] <= init_ctrl(12'(BUF_WORDS * 4));
                buf_q[i]  <= AW'(i * BUF_WORDS);
                link_q[i] <= IDX_W'((i + 1) % N_DESC);
            end else begin
                if (sw_we_i && sw_idx_i == IDX_W'(i) && sw_sel_i == SEL_CTRL)
                    ctrl_q[i] <= dsc_ctrl_t'(sw_wdata_i);
                else if (hw_clr_i && hw_idx_i == IDX_W'(i))
                    ctrl_q[i].owner <= 1'b0;
                if (sw_we_i && sw_idx_i == IDX_W'(i) && sw_sel_i == SEL_BUF)
                    buf_q[i] <= sw_wdata_i[AW-1:0];
                if (sw_we_i && sw_idx_i == IDX_W'(i) && sw_sel_i == SEL_LINK)
                    link_q[i] <= (sw_wdata_i < 32'(N_DESC)) ? sw_wdata_i[IDX_W-1:0] : '0;
            end
        end
    end

    always_comb begin
        case (sw_sel_i)
            SEL_CTRL: sw_rdata_o = ctrl_q[sw_idx_i];
            SEL_BUF:  sw_rdata_o = 32'(buf_q[sw_idx_i]);
            SEL_LINK: sw_rdata_o = 32'(link_q[sw_idx_i]);
            default:  sw_rdata_o = '0;
        endcase
    end

    assign hw_owner_o = ctrl_q[hw_idx_i].owner;
    assign hw_eof_o   = ctrl_q[hw_idx_i].eof;
    assign hw_len_o   = LEN_FROM_BLOCK ? ctrl_q[hw_idx_i].blocksize : ctrl_q[hw_idx_i].datalen;
    assign hw_buf_o   = buf_q[hw_idx_i];
    assign hw_link_o  = link_q[hw_idx_i];

    // Checker: a hardware completion without a competing control write leaves owner clear.
    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk) chk_idx_q <= hw_idx_i;

    assert_owner_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (hw_clr_i && !(sw_we_i && sw_idx_i == hw_idx_i && sw_sel_i == SEL_CTRL))
        |=> !ctrl_q[chk_idx_q].owner);

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int AW      = 12,
    parameter bit CAPTURE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_idx_i,
    input  logic             dsc_owner_i,
    input  logic             dsc_eof_i,
    input  logic [11:0]      dsc_len_i,
    input  logic [AW-1:0]    dsc_buf_i,
    input  logic [IDX_W-1:0] dsc_link_i,
    input  logic             beat_i,
    output logic             active_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             clr_owner_o,
    output logic             eof_evt_o,
    output logic [IDX_W-1:0] eof_idx_o,
    output logic             stall_o
);

    eng_state_t       state_q;
    logic [IDX_W-1:0] cur_q;
    logic [11:0]      cnt_q;
    logic [11:0]      len_q;
    logic [AW-1:0]    base_q;
    logic             eof_q;
    logic [IDX_W-1:0] eof_idx_q;
    logic [11:0]      words;

    assign words = bytes_to_words(dsc_len_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            cnt_q     <= '0;
            len_q     <= '0;
            base_q    <= '0;
            eof_q     <= 1'b0;
            eof_idx_q <= '0;
        end else if (start_i) begin
            state_q <= ST_FETCH;
            cur_q   <= start_idx_i;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    cnt_q  <= '0;
                    len_q  <= words;
                    base_q <= dsc_buf_i;
                    eof_q  <= dsc_eof_i;
                    if (!dsc_owner_i)     state_q <= ST_STALL;
                    else if (words == '0) state_q <= ST_DONE;
                    else                  state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (beat_i) begin
                        cnt_q <= cnt_q + 12'd1;
                        if (cnt_q + 12'd1 == len_q) state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (eof_q) eof_idx_q <= cur_q;
                    cur_q   <= dsc_link_i;
                    state_q <= ST_FETCH;
                end
                ST_STALL: begin
                    if (dsc_owner_i) state_q <= ST_FETCH;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign active_o    = (state_q == ST_XFER);
    assign mem_addr_o  = base_q + AW'(cnt_q);
    assign cur_idx_o   = cur_q;
    assign eof_evt_o   = (state_q == ST_DONE) && eof_q && !start_i;
    assign clr_owner_o = CAPTURE && (state_q == ST_DONE) && !start_i;
    assign eof_idx_o   = eof_idx_q;
    assign stall_o     = (state_q == ST_STALL);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (active_o && !beat_i && !start_i) |=> (active_o && $stable(mem_addr_o)));

    assert_cnt_R2: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (cnt_q < len_q));

    assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !start_i && !dsc_owner_i) |=> (stall_o && !active_o));

endmodule

// File: rtl/ring_dma_irq.sv
module ring_dma_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_i,
    input  logic           clr_we_i,
    input  logic [NCH-1:0] clr_bits_i,
    input  logic [NCH-1:0] en_i,
    output logic [NCH-1:0] sts_o,
    output logic           irq_o
);

    logic [NCH-1:0] sts_q;
    logic [NCH-1:0] clr_mask;

    assign clr_mask = clr_we_i ? clr_bits_i : '0;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~clr_mask) | set_i;
    end

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & en_i);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_set_R5: assert property (@(posedge clk) disable iff (rst)
            set_i[c] |=> sts_q[c]);
        assert_clr_R8: assert property (@(posedge clk) disable iff (rst)
            (clr_we_i && clr_bits_i[c] && !set_i[c]) |=> !sts_q[c]);
    end

endmodule

// File: rtl/ring_dma.sv
module ring_dma
    import ring_dma_pkg::*;
#(
    parameter int N_DESC    = 8,
    parameter int BUF_BYTES = 256,
    parameter int AW        = 12,
    parameter int DW        = 32,
    localparam int IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1,
    localparam int BUF_WORDS = BUF_BYTES / 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       start,
    input  logic [IDX_W-1:0] pb_start_idx,
    input  logic [IDX_W-1:0] cp_start_idx,
    input  logic             dsc_we,
    input  logic             dsc_ch,
    input  logic [IDX_W-1:0] dsc_idx,
    input  logic [1:0]       dsc_sel,
    input  logic [31:0]      dsc_wdata,
    output logic [31:0]      dsc_rdata,
    input  logic [1:0]       irq_en,
    input  logic             sts_we,
    input  logic [1:0]       sts_wdata,
    output logic [1:0]       irq_sts,
    output logic             irq,
    output logic [IDX_W-1:0] pb_eof_idx,
    output logic [IDX_W-1:0] cp_eof_idx,
    output logic [1:0]       stall,
    output logic [AW-1:0]    pb_mem_addr,
    input  logic [DW-1:0]    pb_mem_rdata,
    output logic             pb_valid,
    input  logic             pb_ready,
    output logic [DW-1:0]    pb_data,
    output logic [AW-1:0]    cp_mem_addr,
    output logic             cp_mem_we,
    output logic [DW-1:0]    cp_mem_wdata,
    input  logic             cp_valid,
    output logic             cp_ready,
    input  logic [DW-1:0]    cp_data
);

    localparam int NCH = 2;

    logic [IDX_W-1:0] sidx    [NCH];
    logic [IDX_W-1:0] eidx    [NCH];
    logic [AW-1:0]    maddr   [NCH];
    logic [31:0]      rdata   [NCH];
    logic [NCH-1:0]   beat, act, evt;

    assign sidx[0] = pb_start_idx;
    assign sidx[1] = cp_start_idx;
    assign beat[0] = pb_ready;
    assign beat[1] = cp_valid;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             owner, eof, clr;
        logic [11:0]      len;
        logic [AW-1:0]    bufa;
        logic [IDX_W-1:0] link, cur;

        ring_dma_table #(
            .N_DESC(N_DESC), .BUF_WORDS(BUF_WORDS), .AW(AW), .LEN_FROM_BLOCK(c == 1)
        ) u_tab (
            .clk(clk), .rst(rst),
            .sw_we_i(dsc_we && (dsc_ch == 1'(c))), .sw_idx_i(dsc_idx),
            .sw_sel_i(dsc_sel), .sw_wdata_i(dsc_wdata), .sw_rdata_o(rdata[c]),
            .hw_idx_i(cur), .hw_clr_i(clr),
            .hw_owner_o(owner), .hw_eof_o(eof), .hw_len_o(len),
            .hw_buf_o(bufa), .hw_link_o(link)
        );

        ring_dma_engine #(
            .IDX_W(IDX_W), .AW(AW), .CAPTURE(c == 1)
        ) u_eng (
            .clk(clk), .rst(rst),
            .start_i(start[c]), .start_idx_i(sidx[c]),
            .dsc_owner_i(owner), .dsc_eof_i(eof), .dsc_len_i(len),
            .dsc_buf_i(bufa), .dsc_link_i(link),
            .beat_i(beat[c]), .active_o(act[c]), .mem_addr_o(maddr[c]),
            .cur_idx_o(cur), .clr_owner_o(clr), .eof_evt_o(evt[c]),
            .eof_idx_o(eidx[c]), .stall_o(stall[c])
        );
    end

    ring_dma_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst(rst), .set_i(evt),
        .clr_we_i(sts_we), .clr_bits_i(sts_wdata), .en_i(irq_en),
        .sts_o(irq_sts), .irq_o(irq)
    );

    assign dsc_rdata    = rdata[dsc_ch];
    assign pb_eof_idx   = eidx[0];
    assign cp_eof_idx   = eidx[1];
    assign pb_mem_addr  = maddr[0];
    assign pb_valid     = act[0];
    assign pb_data      = pb_mem_rdata;
    assign cp_mem_addr  = maddr[1];
    assign cp_ready     = act[1];
    assign cp_mem_we    = act[1] && cp_valid;
    assign cp_mem_wdata = cp_data;

endmodule

// File: tb/sim_ring_dma.sv
`timescale 1ns/1ps
module sim_ring_dma;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] start = '0;
    logic [IW-1:0] pb_start_idx = '0, cp_start_idx = '0;
    logic dsc_we = 1'b0, dsc_ch = 1'b0;
    logic [IW-1:0] dsc_idx = '0;
    logic [1:0] dsc_sel = '0;
    logic [31:0] dsc_wdata = '0, dsc_rdata;
    logic [1:0] irq_en = '0;
    logic sts_we = 1'b0;
    logic [1:0] sts_wdata = '0, irq_sts, stall;
    logic irq;
    logic [IW-1:0] pb_eof_idx, cp_eof_idx;
    logic [AW-1:0] pb_mem_addr, cp_mem_addr;
    logic [31:0] pb_mem_rdata, pb_data, cp_mem_wdata;
    logic [31:0] cp_data = '0;
    logic pb_valid, cp_mem_we, cp_ready;
    logic pb_ready = 1'b0, cp_valid = 1'b0;

    logic [31:0] cap_mem [1 << AW];
    logic [31:0] exp_cap [1 << AW];

    int checks = 0, errors = 0;
    int pb_mode = 0;
    int tick = 0;
    bit done = 0;
    logic [31:0] pb_q [$];

    always #2.5 clk = ~clk;

    ring_dma u0 (
        .clk(clk), .rst(rst), .start(start),
        .pb_start_idx(pb_start_idx), .cp_start_idx(cp_start_idx),
        .dsc_we(dsc_we), .dsc_ch(dsc_ch), .dsc_idx(dsc_idx), .dsc_sel(dsc_sel),
        .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
        .irq_en(irq_en), .sts_we(sts_we), .sts_wdata(sts_wdata),
        .irq_sts(irq_sts), .irq(irq),
        .pb_eof_idx(pb_eof_idx), .cp_eof_idx(cp_eof_idx), .stall(stall),
        .pb_mem_addr(pb_mem_addr), .pb_mem_rdata(pb_mem_rdata),
        .pb_valid(pb_valid), .pb_ready(pb_ready), .pb_data(pb_data),
        .cp_mem_addr(cp_mem_addr), .cp_mem_we(cp_mem_we), .cp_mem_wdata(cp_mem_wdata),
        .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_data(cp_data)
    );

    // Playback buffer memory: fixed content derived from the address.
    assign pb_mem_rdata = 32'hA500_0000 | 32'(pb_mem_addr);

    always @(posedge clk) if (cp_mem_we) cap_mem[cp_mem_addr] <= cp_mem_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(bit own, bit eof, int dlen, int blen);
        return {own, eof, 1'b0, 5'b0, 12'(dlen), 12'(blen)};
    endfunction

    task automatic wr_dsc(input bit ch, input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        dsc_we = 1'b1; dsc_ch = ch; dsc_idx = IW'(idx); dsc_sel = 2'(sel); dsc_wdata = d;
        @(posedge clk); #1;
        dsc_we = 1'b0;
    endtask

    task automatic rd_dsc(input bit ch, input int idx, input int sel, output logic [31:0] d);
        @(negedge clk);
        dsc_ch = ch; dsc_idx = IW'(idx); dsc_sel = 2'(sel);
        #1 d = dsc_rdata;
    endtask

    task automatic pulse_start(input int c, input int idx);
        @(negedge clk);
        if (c == 0) pb_start_idx = IW'(idx); else cp_start_idx = IW'(idx);
        start[c] = 1'b1;
        @(posedge clk); #1;
        start = '0;
    endtask

    task automatic clr_sts(input logic [1:0] m);
        @(negedge clk);
        sts_we = 1'b1; sts_wdata = m;
        @(posedge clk); #1;
        sts_we = 1'b0;
    endtask

    task automatic cap_send(input logic [31:0] w, input bit gap);
        if (gap) begin
            @(negedge clk);
            cp_valid = 1'b0;
        end
        forever begin
            @(negedge clk);
            cp_valid = 1'b1; cp_data = w;
            #1;
            if (cp_ready) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Scoreboard monitor: drives pb_ready, pops and compares accepted playback words.
    initial begin
        forever begin
            @(negedge clk);
            tick++;
            pb_ready = (pb_q.size() > 0) && (pb_mode == 0 || (tick % 3) != 0);
            #1;
            if (pb_valid && pb_ready) begin
                logic [31:0] e;
                e = pb_q.pop_front();
                chk(pb_data == e, "R2/R3 playback word", pb_data, e);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int plen [N];
        int plink [N];
        int order [7];
        int cidx, clen, k, blen;

        for (int a = 0; a < (1 << AW); a++) begin
            cap_mem[a] = 32'h0;
            exp_cap[a] = 32'h0;
        end

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset contents (control bits: blocksize 11:0, datalen 23:12, eof 30, owner 31)
        rd_dsc(0, 3, 0, r); chk(r == 32'hC010_0100, "R1 ctrl init", r, 32'hC010_0100);
        rd_dsc(0, 3, 1, r); chk(r == 32'd192, "R1 buf init", r, 32'd192);
        rd_dsc(0, 3, 2, r); chk(r == 32'd4, "R1 link init", r, 32'd4);
        rd_dsc(0, 7, 2, r); chk(r == 32'd0, "R1 ring wrap link", r, 32'd0);
        rd_dsc(1, 5, 1, r); chk(r == 32'd320, "R1 capture buf init R10", r, 32'd320);
        chk(irq_sts == 2'b00 && stall == 2'b00, "R1 status reset", {28'd0, irq_sts, stall}, 32'd0);
        chk(!pb_valid && !cp_ready, "R1 idle streams", {30'd0, pb_valid, cp_ready}, 32'd0);

        // Playback ring: desc1 links to 3, desc5 is 2 words, eof on 3 and 7.
        for (int i = 0; i < N; i++) begin
            plen[i]  = (i == 5) ? 8 : 16;
            plink[i] = (i + 1) % N;
            wr_dsc(0, i, 0, ctrl_word(1, (i == 3 || i == 7), plen[i], 256));
        end
        plink[1] = 3;
        wr_dsc(0, 1, 2, 32'd3);
        rd_dsc(0, 1, 2, r); chk(r == 32'd3, "R10 link write readback", r, 32'd3);

        pb_mode = 1;
        pulse_start(0, 0);
        cidx = 0;
        for (int s = 0; s < 7; s++) begin
            order[s] = cidx;
            for (int w = 0; w < plen[cidx] / 4; w++)
                pb_q.push_back(32'hA500_0000 | 32'(cidx * 64 + w));
            cidx = plink[cidx];
        end
        while (pb_q.size() > 0) @(posedge clk);
        idle(6);
        @(negedge clk);
        chk(irq_sts[0] == 1'b1, "R5 playback eof status", {31'd0, irq_sts[0]}, 32'd1);
        chk(pb_eof_idx == 3'd7, "R5 playback eof index", 32'(pb_eof_idx), 32'd7);
        chk(pb_valid && pb_mem_addr == 12'd0, "R3 held at next descriptor", 32'(pb_mem_addr), 32'd0);
        irq_en = 2'b00; #1;
        chk(irq == 1'b0, "R8 irq masked", {31'd0, irq}, 32'd0);
        irq_en = 2'b01; #1;
        chk(irq == 1'b1, "R8 irq enabled", {31'd0, irq}, 32'd1);
        rd_dsc(0, order[2], 0, r); chk(r[31] == 1'b1, "R6 playback keeps owner", 32'(r[31]), 32'd1);
        clr_sts(2'b11);
        #1 chk(irq_sts == 2'b00 && irq == 1'b0, "R8 clear by ones", {30'd0, irq_sts}, 32'd0);

        // Restart at desc4 (eof=0) for exactly one descriptor: R9, R5 no eof.
        pb_mode = 0;
        pulse_start(0, 4);
        for (int w = 0; w < 4; w++) pb_q.push_back(32'hA500_0000 | 32'(256 + w));
        while (pb_q.size() > 0) @(posedge clk);
        idle(5);
        @(negedge clk);
        chk(irq_sts[0] == 1'b0, "R5 eof clear gives no status", {31'd0, irq_sts[0]}, 32'd0);
        chk(pb_eof_idx == 3'd7, "R5 eof index unchanged", 32'(pb_eof_idx), 32'd7);
        chk(pb_valid && pb_mem_addr == 12'd320, "R9 R2 next desc after restart", 32'(pb_mem_addr), 32'd320);

        // Capture ring: 4 words per desc, desc2 is 2 words with eof=0.
        for (int i = 0; i < N; i++)
            wr_dsc(1, i, 0, ctrl_word(1, (i != 2), 256, (i == 2) ? 8 : 16));
        pulse_start(1, 0);
        k = 0;
        for (int i = 0; i < N; i++) begin
            blen = (i == 2) ? 2 : 4;
            for (int w = 0; w < blen; w++) begin
                exp_cap[i * 64 + w] = 32'hC0DE_0000 + 32'(k);
                cap_send(32'hC0DE_0000 + 32'(k), (k % 5) == 4);
                k++;
            end
        end
        @(negedge clk) cp_valid = 1'b0;
        idle(8);
        @(negedge clk);
        chk(stall[1] == 1'b1 && !cp_ready, "R7 capture stalls on own=0", {30'd0, stall[1], cp_ready}, 32'd2);
        chk(irq_sts[1] == 1'b1 && cp_eof_idx == 3'd7, "R5 capture eof", {28'd0, irq_sts[1], cp_eof_idx}, 32'hF);
        clen = 0;
        for (int i = 0; i < N; i++)
            for (int w = 0; w < 4; w++)
                if (cap_mem[i * 64 + w] != exp_cap[i * 64 + w]) clen++;
        chk(clen == 0, "R4 capture memory", 32'(clen), 32'd0);
        rd_dsc(1, 0, 0, r); chk(r[31] == 1'b0, "R6 capture clears owner desc0", 32'(r[31]), 32'd0);
        rd_dsc(1, 2, 0, r); chk(r[31] == 1'b0, "R6 capture clears owner desc2", 32'(r[31]), 32'd0);

        // Junk while stalled must be ignored (R7).
        @(negedge clk) cp_valid = 1'b1; cp_data = 32'hDEAD_DEAD;
        idle(5);
        @(negedge clk) cp_valid = 1'b0;
        chk(cap_mem[0] == exp_cap[0] && !cp_ready, "R7 stalled input ignored", cap_mem[0], exp_cap[0]);

        // Return desc0 only (eof=0): one block lands, then stall on desc1.
        wr_dsc(1, 0, 0, ctrl_word(1, 0, 256, 16));
        for (int w = 0; w < 4; w++) begin
            exp_cap[w] = 32'hBEEF_0000 + 32'(w);
            cap_send(32'hBEEF_0000 + 32'(w), 1'b0);
        end
        @(negedge clk) cp_valid = 1'b0;
        idle(6);
        @(negedge clk);
        clen = 0;
        for (int w = 0; w < 4; w++) if (cap_mem[w] != exp_cap[w]) clen++;
        chk(clen == 0, "R7 resume after owner return", 32'(clen), 32'd0);
        chk(cap_mem[64] == exp_cap[64], "R4 desc1 untouched", cap_mem[64], exp_cap[64]);
        chk(stall[1] == 1'b1, "R7 stall on desc1", {31'd0, stall[1]}, 32'd1);
        chk(cp_eof_idx == 3'd7, "R5 capture eof=0 keeps index", 32'(cp_eof_idx), 32'd7);
        rd_dsc(1, 0, 0, r); chk(r[31] == 1'b0, "R6 owner cleared again", 32'(r[31]), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule